// File: doc/BRIEF.md
# Cartridge Bank Latch and Decoder

This block is the glue logic of a 6502-bus cartridge that carries a boot flash, a PRG static RAM, a CHR static RAM and a memory-mapped network controller. It watches the CPU phase clock M2, the active-low cartridge ROM select, R/W and address lines A14..A0. From these it decodes the $6000-$7FFF window, and it steers the $8000-$FFFF range to either the flash or the PRG RAM.

Two 4-bit bank registers sit in the $6xxx half of the window. A read from $6xxx captures the low address nibble as the PRG bank, so software selects a bank by which address it reads. A write to $6xxx captures the low data nibble as the CHR bank. The PRG bank picks a 32 KiB slice shown at $8000-$FFFF. Its top bit decides which chip answers, and its two low bits become the memory's upper address lines. The CHR bank picks an 8 KiB slice of the CHR RAM. The $7xxx half drives the network controller's read and write strobes directly.

The registers are sampled on the rising edge of `clk`, which runs faster than the CPU bus, so that a load completes while M2 is still high. All outputs other than the two bank values are combinational from the bus and the PRG bank.

Top module: `cart_bank_glue`

## Requirements
- R1: `winSelN` is low exactly when `m2`, `romSelN`, A14 and A13 are all high, that is, during a CPU access to $6000-$7FFF.
- R2: Inside the window, A12=0 with `rwN`=1 is a bank read, A12=0 with `rwN`=0 is a bank write, A12=1 with `rwN`=1 drives `nicRdN` low, and A12=1 with `rwN`=0 drives `nicWrN` low. At most one of these four decodes is active at a time.
- R3: On a rising `clk` edge during a bank read, the PRG bank takes `cpuAddr[3:0]`.
- R4: On a rising `clk` edge during a bank write, `chrBank` takes `cpuData[3:0]`.
- R5: While `rstN` is low, both bank registers are zero.
- R6: No other access changes either bank register. This covers $7xxx accesses, $8000-$FFFF accesses and idle cycles.
- R7: During an access to $8000-$FFFF (`m2` high and `romSelN` low), `romCeN` is low if PRG bank bit 3 is 0, and `ramCeN` is low if it is 1. The two are never low together, and both are high otherwise.
- R8: `prgAddr[16:15]` equals PRG bank bits 1..0, and `prgAddr[14:0]` equals `cpuAddr[14:0]`.
- R9: While `m2` is low, every strobe and chip select is high.
- R10: During an access to $8000-$FFFF, `prgOeN` is low when `rwN`=1 and `prgWeN` is low when `rwN`=0. Outside such an access, both are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for the bank registers |
| rstN | input | 1 | Hardware reset, active low, asynchronous |
| m2 | input | 1 | CPU phase-2 clock |
| romSelN | input | 1 | Cartridge ROM select from the console, active low |
| rwN | input | 1 | CPU read (1) / write (0) |
| cpuAddr | input | 15 | CPU address A14..A0 |
| cpuData | input | 4 | CPU data D3..D0 |
| winSelN | output | 1 | $6000-$7FFF window select, active low |
| nicRdN | output | 1 | Network controller read strobe, active low |
| nicWrN | output | 1 | Network controller write strobe, active low |
| romCeN | output | 1 | Boot flash chip enable, active low |
| ramCeN | output | 1 | PRG RAM chip enable, active low |
| prgOeN | output | 1 | PRG memory output enable, active low |
| prgWeN | output | 1 | PRG memory write enable, active low |
| prgAddr | output | 17 | PRG memory address: bank bits 1..0 above A14..A0 |
| chrBank | output | 4 | CHR RAM slice select, drives its A16..A13 |

## Verification
The PRG bank register has no direct output. Its value can be seen only through the chip selects and the upper address bits, and only during an access to $8000-$FFFF. The bench therefore follows every register-touching access with a later cartridge read or write and compares the steering against its own model. A directed pass loads each of the sixteen PRG values by reading $6xxx with that value in the low address nibble. Each load is followed by a read and a write at $8000-$FFFF, so that both devices and every slice are reached. The exhaustive bus sweep interleaves $7xxx and $8000-$FFFF accesses, which must leave both banks untouched.

// File: rtl/cart_glue_pkg.sv
package cart_glue_pkg;
  // Decoded bus events, passed from control to datapath
  typedef struct packed {
    logic winHit;   // $6000-$7FFF access in progress
    logic bankRd;   // read of $6xxx
    logic bankWr;   // write of $6xxx
    logic nicRd;    // read of $7xxx
    logic nicWr;    // write of $7xxx
    logic cartHit;  // $8000-$FFFF access in progress
    logic prgRd;
    logic prgWr;
  } glueStrb_t;
endpackage

// File: rtl/cart_glue_ctrl.sv
module cart_glue_ctrl
  import cart_glue_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      m2,
  input  logic      romSelN,
  input  logic      rwN,
  input  logic      a14,
  input  logic      a13,
  input  logic      a12,
  output glueStrb_t strb
);
  logic inWindow;
  logic inCart;

  // romSelN high with M2 high means A15 low; A14 and A13 finish the $6000 match
  assign inWindow = m2 & romSelN & a14 & a13;
  assign inCart   = m2 & ~romSelN;

  always_comb begin
    strb         = '0;
    strb.winHit  = inWindow;
    strb.bankRd  = inWindow & ~a12 &  rwN;
    strb.bankWr  = inWindow & ~a12 & ~rwN;
    strb.nicRd   = inWindow &  a12 &  rwN;
    strb.nicWr   = inWindow &  a12 & ~rwN;
    strb.cartHit = inCart;
    strb.prgRd   = inCart &  rwN;
    strb.prgWr   = inCart & ~rwN;
  end

  // R2: the four window decodes are mutually exclusive
  a_r2_window_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.bankRd, strb.bankWr, strb.nicRd, strb.nicWr}));

  // R9: nothing decodes during the first half of the CPU cycle
  a_r9_m2_low_idle: assert property (@(posedge clk) disable iff (!rstN)
    !m2 |-> (strb == '0));

  // R1/R7: window and cartridge range never overlap
  a_r1_ranges_disjoint: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.winHit && strb.cartHit));
endmodule

// File: rtl/cart_glue_dp.sv
module cart_glue_dp
  import cart_glue_pkg::*;
#(
  parameter int BANK_W     = 4,
  parameter int SLICE_BITS = 2,
  parameter int CPU_AW     = 15
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  glueStrb_t                    strb,
  input  logic [CPU_AW-1:0]            cpuAddr,
  input  logic [BANK_W-1:0]            cpuData,
  output logic                         romCeN,
  output logic                         ramCeN,
  output logic                         prgOeN,
  output logic                         prgWeN,
  output logic [SLICE_BITS+CPU_AW-1:0] prgAddr,
  output logic [BANK_W-1:0]            chrBank
);
  localparam int DEV_BIT = BANK_W - 1;

  logic [BANK_W-1:0] prgBank;
  logic [BANK_W-1:0] chrReg;
  logic              unusedPrgBits;

  // PRG bank: captured from the address lines on a read of $6xxx
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            prgBank <= '0;
    else if (strb.bankRd) prgBank <= cpuAddr[BANK_W-1:0];
  end

  // CHR bank: captured from the data lines on a write of $6xxx
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            chrReg <= '0;
    else if (strb.bankWr) chrReg <= cpuData;
  end

  // Bits between the slice bits and the device bit take no part in steering
  generate
    if (DEV_BIT > SLICE_BITS) begin : g_mid
      assign unusedPrgBits = ^prgBank[DEV_BIT-1:SLICE_BITS];
    end else begin : g_nomid
      assign unusedPrgBits = 1'b0;
    end
  endgenerate

  assign romCeN  = ~(strb.cartHit & ~prgBank[DEV_BIT]);
  assign ramCeN  = ~(strb.cartHit &  prgBank[DEV_BIT]);
  assign prgOeN  = ~strb.prgRd;
  assign prgWeN  = ~strb.prgWr;
  assign prgAddr = {prgBank[SLICE_BITS-1:0], cpuAddr};
  assign chrBank = chrReg;

  // R3: PRG bank follows the address nibble of a $6xxx read
  a_r3_prg_load: assert property (@(posedge clk) disable iff (!rstN)
    strb.bankRd |=> prgBank == $past(cpuAddr[BANK_W-1:0]));

  // R4: CHR bank follows the data nibble of a $6xxx write
  a_r4_chr_load: assert property (@(posedge clk) disable iff (!rstN)
    strb.bankWr |=> chrBank == $past(cpuData));

  // R6: no other access disturbs the banks
  a_r6_prg_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strb.bankRd |=> $stable(prgBank));
  a_r6_chr_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strb.bankWr |=> $stable(chrBank));

  // R7: flash and PRG RAM are never enabled together
  a_r7_one_device: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({~romCeN, ~ramCeN}));
endmodule

// File: rtl/cart_bank_glue.sv
module cart_bank_glue
  import cart_glue_pkg::*;
#(
  parameter int BANK_W     = 4,
  parameter int SLICE_BITS = 2,
  parameter int CPU_AW     = 15
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         m2,
  input  logic                         romSelN,
  input  logic                         rwN,
  input  logic [CPU_AW-1:0]            cpuAddr,
  input  logic [BANK_W-1:0]            cpuData,
  output logic                         winSelN,
  output logic                         nicRdN,
  output logic                         nicWrN,
  output logic                         romCeN,
  output logic                         ramCeN,
  output logic                         prgOeN,
  output logic                         prgWeN,
  output logic [SLICE_BITS+CPU_AW-1:0] prgAddr,
  output logic [BANK_W-1:0]            chrBank
);
  glueStrb_t strb;

  cart_glue_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .m2      (m2),
    .romSelN (romSelN),
    .rwN     (rwN),
    .a14     (cpuAddr[CPU_AW-1]),
    .a13     (cpuAddr[CPU_AW-2]),
    .a12     (cpuAddr[CPU_AW-3]),
    .strb    (strb)
  );

  cart_glue_dp #(
    .BANK_W     (BANK_W),
    .SLICE_BITS (SLICE_BITS),
    .CPU_AW     (CPU_AW)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .cpuAddr (cpuAddr),
    .cpuData (cpuData),
    .romCeN  (romCeN),
    .ramCeN  (ramCeN),
    .prgOeN  (prgOeN),
    .prgWeN  (prgWeN),
    .prgAddr (prgAddr),
    .chrBank (chrBank)
  );

  // The network controller strobes come straight from the $7xxx decodes
  assign winSelN = ~strb.winHit;
  assign nicRdN  = ~strb.nicRd;
  assign nicWrN  = ~strb.nicWr;
endmodule

// File: tb/tb_cart_bank_glue.sv
`timescale 1ns/1ps
module tb_cart_bank_glue;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        m2 = 1'b0;
  logic        romSelN = 1'b1;
  logic        rwN = 1'b1;
  logic [14:0] cpuAddr = '0;
  logic [3:0]  cpuData = '0;
  logic        winSelN, nicRdN, nicWrN, romCeN, ramCeN, prgOeN, prgWeN;
  logic [16:0] prgAddr;
  logic [3:0]  chrBank;

  int checks = 0;
  int errors = 0;
  logic [3:0] mPrg = '0;
  logic [3:0] mChr = '0;

  always #2.5 clk = ~clk;

  cart_bank_glue dut (
    .clk(clk), .rstN(rstN), .m2(m2), .romSelN(romSelN), .rwN(rwN),
    .cpuAddr(cpuAddr), .cpuData(cpuData), .winSelN(winSelN),
    .nicRdN(nicRdN), .nicWrN(nicWrN), .romCeN(romCeN), .ramCeN(ramCeN),
    .prgOeN(prgOeN), .prgWeN(prgWeN), .prgAddr(prgAddr), .chrBank(chrBank)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Compares every combinational output against the model
  task automatic checkComb();
    logic win, cart;
    win  = m2 & romSelN & cpuAddr[14] & cpuAddr[13];
    cart = m2 & ~romSelN;
    chk("R1 winSelN", winSelN, !win);
    chk("R2 nicRdN", nicRdN, !(win & cpuAddr[12] & rwN));
    chk("R2 nicWrN", nicWrN, !(win & cpuAddr[12] & !rwN));
    chk("R7 romCeN", romCeN, !(cart & !mPrg[3]));
    chk("R7 ramCeN", ramCeN, !(cart & mPrg[3]));
    chk("R10 prgOeN", prgOeN, !(cart & rwN));
    chk("R10 prgWeN", prgWeN, !(cart & !rwN));
    chk("R8 prgAddr", prgAddr, {mPrg[1:0], cpuAddr});
    if (!m2) chk("R9 idle", {winSelN, nicRdN, nicWrN, romCeN, ramCeN, prgOeN, prgWeN}, 7'h7f);
  endtask

  // One bus access: drive at the falling edge, check, let the rising edge sample
  task automatic access(input logic im2, input logic irs, input logic irw,
                        input logic [14:0] ia, input logic [3:0] id);
    logic win;
    @(negedge clk);
    m2 = im2; romSelN = irs; rwN = irw; cpuAddr = ia; cpuData = id;
    #1;
    checkComb();
    win = im2 & irs & ia[14] & ia[13];
    @(posedge clk);
    if (win & !ia[12] & irw)  mPrg = ia[3:0];  // R3
    if (win & !ia[12] & !irw) mChr = id;       // R4
    #1;
    chk("R4 R6 chrBank", chrBank, mChr);
    checkComb();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R5 reset chrBank", chrBank, 4'h0);
    chk("R5 reset prgAddr hi", prgAddr[16:15], 2'b00);
    @(negedge clk);
    rstN = 1'b1;

    // Exhaustive sweep over M2, /ROMSEL, R/W, A14..A12 and the low nibble
    for (int c = 0; c < 64; c++) begin
      for (int n = 0; n < 16; n++) begin
        logic [14:0] a;
        a = {c[2:0], 8'h5a, n[3:0]};
        access(c[5], c[4], c[3], a, 4'((n * 7 + 3 + c) & 15));
        // follow with a cartridge read so the PRG bank is observed (R3, R6)
        access(1'b1, 1'b0, 1'b1, 15'(n * 1234 + c), 4'h0);
      end
    end

    // Directed: every PRG bank value, then a read and a write at $8000+ (R7, R8)
    for (int b = 0; b < 16; b++) begin
      access(1'b1, 1'b1, 1'b1, {3'b110, 8'h00, b[3:0]}, 4'hf);
      access(1'b1, 1'b0, 1'b1, 15'h7ffc, 4'h0);
      access(1'b1, 1'b0, 1'b0, 15'h0123, 4'h9);
      chk("R7 device pick", {romCeN, ramCeN}, b[3] ? 2'b10 : 2'b01);
      access(1'b1, 1'b1, 1'b0, 15'h7fff, 4'h0);  // $7xxx write keeps banks (R6)
      chk("R6 prg after nic write", prgAddr[16:15], b[1:0]);
    end

    // Reset clears non-zero banks (R5)
    access(1'b1, 1'b1, 1'b1, 15'h600f, 4'h0);
    access(1'b1, 1'b1, 1'b0, 15'h6000, 4'hb);
    @(negedge clk);
    m2 = 1'b1; romSelN = 1'b0; rwN = 1'b1;
    rstN = 1'b0;
    mPrg = '0; mChr = '0;
    #1;
    chk("R5 reset prg", {romCeN, ramCeN, prgAddr[16:15]}, 4'b0100);
    chk("R5 reset chr", chrBank, 4'h0);
    @(negedge clk);
    rstN = 1'b1;
    access(1'b1, 1'b0, 1'b1, 15'h1234, 4'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule